// File: doc/BRIEF.md
# Two-Wire Serial Configuration Memory Slave

This block is the slave side of a two-wire serial link in front of a small byte-wide memory built from registers. The clock line and the open-drain data line are inputs that are sampled against the system clock. The slave answers on the data line only by pulling it low, through `sda_drive_low`. The interface works only while `ser_en_n` is low. The block finds start and stop conditions and checks a 7-bit device address. On a write it takes a two-byte memory address, most-significant byte first, and then any number of data bytes. On a read it sends bytes from its internal pointer for as long as the master acknowledges them.

Written bytes go into a small buffer. They reach the array only during the timed write cycle that a stop condition starts. While that cycle runs, `busy` is high and both bus lines are ignored. A host first writes the address and data and sends a stop. It then waits until the slave answers its address again, and after that it reads back with an address-only write followed by a current-address read.

The controller is one state machine:
- States: `ST_IDLE`, `ST_DEVADDR`, `ST_DEV_ACK`, `ST_ADDR_HI`, `ST_ADDR_HI_ACK`, `ST_ADDR_LO`, `ST_ADDR_LO_ACK`, `ST_WDATA`, `ST_WDATA_ACK`, `ST_RDATA`, `ST_RACK`, `ST_BUSY`.
- A start goes to `ST_DEVADDR` from any state except `ST_BUSY`.
- In `ST_DEVADDR`, a matching address goes to `ST_DEV_ACK` and any other address goes to `ST_IDLE`.
- From `ST_DEV_ACK`, a read goes to `ST_RDATA` and a write goes to `ST_ADDR_HI`.
- The write path runs `ST_ADDR_HI`, `ST_ADDR_HI_ACK`, `ST_ADDR_LO`, `ST_ADDR_LO_ACK` and then `ST_WDATA`. After that it alternates between `ST_WDATA` and `ST_WDATA_ACK`.
- The read path alternates between `ST_RDATA` and `ST_RACK`. A master acknowledge leads back to `ST_RDATA` and a master no-acknowledge leads to `ST_IDLE`.
- A stop in `ST_WDATA` or `ST_WDATA_ACK` with buffered bytes goes to `ST_BUSY`. A stop anywhere else goes to `ST_IDLE`.
- `ST_BUSY` returns to `ST_IDLE` when the write cycle ends.
- `ser_en_n` high forces `ST_IDLE` from every state except `ST_BUSY`.

Top module: `cfg_serial_mem_slave`

## Requirements
- R1: After reset `busy` is low, `sda_drive_low` is low, the pointer is 0 and every array byte reads back as 0x00.
- R2: The slave acknowledges a device byte whose upper seven bits equal DEV_ADDR. Bit 0 of that byte selects the direction: 1 means read and 0 means write. Any other device byte gets no acknowledge, and the slave then acknowledges nothing until the next start.
- R3: A write sends the high address byte and then the low address byte. The slave uses the 16-bit value modulo MEM_DEPTH. Each data byte is acknowledged by a low data line during the ninth clock, and the data bytes land at successive addresses that wrap from MEM_DEPTH-1 to 0. The slave changes its drive only while the clock is low.
- R4: A stop after at least one acknowledged data byte holds `busy` high for exactly WR_CYCLES clocks. The buffered bytes reach the array during that time.
- R5: While `busy` is high the slave ignores both lines: a start followed by a matching device byte gets no acknowledge, and the slave never drives the line.
- R6: A write with an address but no data bytes, followed by a stop, only loads the pointer. It starts no write cycle.
- R7: A current-address read returns the byte at the pointer. It keeps returning following bytes, wrapping at the top of the array, while the master acknowledges. After a master no-acknowledge the slave releases the line.
- R8: After a committed write the pointer is one past the last byte written, so a current-address read returns the next location.
- R9: A start that arrives before the stop of a write throws away the bytes buffered so far. Nothing is committed and `busy` stays low.
- R10: At most BUF_DEPTH data bytes are acknowledged per write. Bytes past that limit get no acknowledge and are never stored.
- R11: While `ser_en_n` is high the slave never drives the line and acknowledges no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en_n | input | 1 | Active-low serial interface enable |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Data line level as seen on the wire |
| sda_drive_low | output | 1 | High pulls the data line low |
| busy | output | 1 | Timed write cycle in progress |

## Verification
The case that is hardest to reach is bus traffic arriving inside the write cycle. The stimulus sends a stop to start a write cycle. It then sends a start and a matching read address at once, while the write cycle runs. WR_CYCLES is set longer than one whole byte, so the missing acknowledge shows that the slave ignored the bus, not that the cycle had already ended. The other hard cases are a write that a repeated start cuts off before its stop, and the byte after a full buffer. In both, the check reads back the old array contents afterwards.

// File: rtl/cfg_slave_pkg.sv
package cfg_slave_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEV_ACK,
        ST_ADDR_HI,
        ST_ADDR_HI_ACK,
        ST_ADDR_LO,
        ST_ADDR_LO_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_BUSY
    } slave_state_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/cfg_bus_sense.sv
module cfg_bus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // one extra stage beyond the synchronizer holds the previous sampled level
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] scl_pipe;
    logic [PIPE_W-1:0] sda_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_i};
            sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;

    assign scl_now = scl_pipe[SYNC_STAGES-1];
    assign scl_old = scl_pipe[SYNC_STAGES];
    assign sda_now = sda_pipe[SYNC_STAGES-1];
    assign sda_old = sda_pipe[SYNC_STAGES];

    assign sda_s     = sda_now;
    assign scl_rise  = scl_now && !scl_old;
    assign scl_fall  = !scl_now && scl_old;
    assign start_det = scl_now && scl_old && sda_old && !sda_now;
    assign stop_det  = scl_now && scl_old && !sda_old && sda_now;

    // R3: a start or stop is seen only while the clock stays high
    AST_COND_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |-> $past(scl_pipe[SYNC_STAGES-1])); // R3

endmodule

// File: rtl/cfg_wr_buffer.sv
module cfg_wr_buffer #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic [$clog2(DEPTH)-1:0]     rd_idx,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0] slots [DEPTH];

    assign full = (count == CW'(DEPTH));
    assign dout = slots[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (push && !full) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full && !clear) begin
            slots[count[IW-1:0]] <= din;
        end
    end

    AST_BUF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R10

    AST_BUF_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clear) |=> $stable(count)); // R10

endmodule

// File: rtl/cfg_mem_array.sv
module cfg_mem_array #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [$clog2(DEPTH)-1:0]  waddr,
    input  logic [W-1:0]              wdata,
    input  logic [$clog2(DEPTH)-1:0]  raddr,
    output logic [W-1:0]              rdata
);
    localparam int AW = $clog2(DEPTH);

    logic [DEPTH-1:0][W-1:0] words;

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_word
            logic [W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (we && waddr == AW'(gi)) begin
                    q <= wdata;
                end
            end
            assign words[gi] = q;
        end
    endgenerate

    assign rdata = words[raddr];

endmodule

// File: rtl/cfg_serial_mem_slave.sv
module cfg_serial_mem_slave
    import cfg_slave_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h50,
    parameter int         MEM_DEPTH = 16,
    parameter int         BUF_DEPTH = 4,
    parameter int         WR_CYCLES = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_en_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_drive_low,
    output logic busy
);
    localparam int AW   = $clog2(MEM_DEPTH);
    localparam int BIW  = $clog2(BUF_DEPTH);
    localparam int BCW  = $clog2(BUF_DEPTH + 1);
    localparam int CNTW = $clog2(WR_CYCLES);

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;

    cfg_bus_sense #(.SYNC_STAGES(2)) u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    slave_state_t      state, state_nx;
    logic [BYTE_W-1:0] sr;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] addr_hi;
    logic [AW-1:0]     ptr;
    logic [AW-1:0]     wr_base;
    logic              mack;
    logic [CNTW-1:0]   cyc_cnt;
    logic [BCW-1:0]    commit_idx;

    logic              buf_clear, buf_push, buf_full;
    logic [BCW-1:0]    buf_count;
    logic [BYTE_W-1:0] buf_dout;
    logic [BYTE_W-1:0] mem_rdata;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr;

    logic bus_live, byte_end, rx_state, in_write, cyc_last;

    assign bus_live = (state != ST_BUSY) && !ser_en_n;
    assign byte_end = scl_fall && (bitcnt == 4'd8);
    assign rx_state = (state == ST_DEVADDR) || (state == ST_ADDR_HI) ||
                      (state == ST_ADDR_LO) || (state == ST_WDATA);
    assign in_write = (state == ST_WDATA) || (state == ST_WDATA_ACK);
    assign cyc_last = (cyc_cnt == CNTW'(WR_CYCLES - 1));

    // ---------------- next-state logic ----------------
    always_comb begin
        state_nx = state;
        if (state == ST_BUSY) begin
            if (cyc_last) state_nx = ST_IDLE;
        end else if (ser_en_n) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_DEVADDR;
        end else if (stop_det) begin
            state_nx = (in_write && buf_count != '0) ? ST_BUSY : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:        state_nx = ST_IDLE;
                ST_DEVADDR:     if (byte_end)
                                    state_nx = (sr[7:1] == DEV_ADDR) ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:     if (scl_fall)
                                    state_nx = sr[0] ? ST_RDATA : ST_ADDR_HI;
                ST_ADDR_HI:     if (byte_end) state_nx = ST_ADDR_HI_ACK;
                ST_ADDR_HI_ACK: if (scl_fall) state_nx = ST_ADDR_LO;
                ST_ADDR_LO:     if (byte_end) state_nx = ST_ADDR_LO_ACK;
                ST_ADDR_LO_ACK: if (scl_fall) state_nx = ST_WDATA;
                ST_WDATA:       if (byte_end && !buf_full) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK:   if (scl_fall) state_nx = ST_WDATA;
                ST_RDATA:       if (scl_fall && bitcnt == 4'd7) state_nx = ST_RACK;
                ST_RACK:        if (scl_fall) state_nx = mack ? ST_RDATA : ST_IDLE;
                ST_BUSY:        state_nx = ST_BUSY;
            endcase
        end
    end

    // ---------------- state register and datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sr      <= '0;
            bitcnt  <= '0;
            addr_hi <= '0;
            ptr     <= '0;
            wr_base <= '0;
            mack    <= 1'b0;
        end else begin
            state <= state_nx;

            if (state_nx == ST_RDATA && state != ST_RDATA) begin
                sr     <= mem_rdata;
                bitcnt <= '0;
            end else if (state_nx != state || (bus_live && start_det) ||
                         (state == ST_WDATA && byte_end && bus_live)) begin
                bitcnt <= '0;
            end else if (bus_live && rx_state && scl_rise) begin
                sr     <= {sr[BYTE_W-2:0], sda_s};
                bitcnt <= bitcnt + 4'd1;
            end else if (bus_live && state == ST_RDATA && scl_fall) begin
                sr     <= {sr[BYTE_W-2:0], 1'b0};
                bitcnt <= bitcnt + 4'd1;
            end

            if (bus_live && !start_det && !stop_det) begin
                if (state == ST_ADDR_HI && byte_end) begin
                    addr_hi <= sr;
                end
                if (state == ST_ADDR_LO && byte_end) begin
                    ptr     <= AW'(({addr_hi, sr}) % MEM_DEPTH);
                    wr_base <= AW'(({addr_hi, sr}) % MEM_DEPTH);
                end
                if ((state == ST_WDATA && byte_end && !buf_full) ||
                    (state == ST_RDATA && scl_fall && bitcnt == 4'd7)) begin
                    ptr <= ptr + 1'b1;
                end
                if (state == ST_RACK && scl_rise) begin
                    mack <= !sda_s;
                end
            end
        end
    end

    // ---------------- timed write cycle ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_cnt    <= '0;
            commit_idx <= '0;
        end else if (state == ST_BUSY) begin
            cyc_cnt <= cyc_cnt + 1'b1;
            if (commit_idx < buf_count) commit_idx <= commit_idx + 1'b1;
        end else begin
            cyc_cnt    <= '0;
            commit_idx <= '0;
        end
    end

    assign buf_push  = bus_live && !start_det && !stop_det &&
                       (state == ST_WDATA) && byte_end;
    assign buf_clear = (state != ST_BUSY && (ser_en_n || start_det)) ||
                       (state == ST_BUSY && cyc_last);
    assign mem_we    = (state == ST_BUSY) && (commit_idx < buf_count);
    assign mem_waddr = wr_base + AW'(commit_idx);

    cfg_wr_buffer #(.DEPTH(BUF_DEPTH), .W(BYTE_W)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (buf_clear),
        .push   (buf_push),
        .din    (sr),
        .rd_idx (commit_idx[BIW-1:0]),
        .dout   (buf_dout),
        .count  (buf_count),
        .full   (buf_full)
    );

    cfg_mem_array #(.DEPTH(MEM_DEPTH), .W(BYTE_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (buf_dout),
        .raddr (ptr),
        .rdata (mem_rdata)
    );

    // ---------------- outputs ----------------
    always_comb begin
        sda_drive_low = 1'b0;
        unique case (state)
            ST_DEV_ACK, ST_ADDR_HI_ACK, ST_ADDR_LO_ACK, ST_WDATA_ACK:
                sda_drive_low = 1'b1;
            ST_RDATA:
                sda_drive_low = !sr[BYTE_W-1];
            default:
                sda_drive_low = 1'b0;
        endcase
        busy = (state == ST_BUSY);
    end

    // ---------------- assertions ----------------
    AST_DRIVE_ON_LOW_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> $past(scl_fall)); // R3

    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det)); // R4

    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_drive_low); // R5

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en_n && $past(ser_en_n)) |-> !sda_drive_low); // R11

    AST_COMMIT_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R4

endmodule

// File: tb/cfg_serial_mem_slave_test.sv
module cfg_serial_mem_slave_test;

    localparam int         Q   = 8;
    localparam int         WRC = 600;
    localparam logic [6:0] DEV = 7'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_en_n = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    wire  sda_drive_low;
    wire  busy;
    wire  sda_line = sda_m & ~sda_drive_low;

    always #2.5 clk = ~clk;

    cfg_serial_mem_slave #(
        .DEV_ADDR(DEV), .MEM_DEPTH(16), .BUF_DEPTH(4), .WR_CYCLES(WRC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ser_en_n(ser_en_n),
        .scl_i(scl_m), .sda_i(sda_line),
        .sda_drive_low(sda_drive_low), .busy(busy)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // scoreboard
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got_byte;
    event       got_ev;

    initial begin
        forever begin
            @(got_ev);
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard extra byte", int'(got_byte), 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(got_byte == e, t, int'(got_byte), int'(e));
            end
        end
    end

    task automatic expect_byte(input logic [7:0] b, input string tag);
        exp_q.push_back(b);
        tag_q.push_back(tag);
    endtask

    // busy pulse monitor
    int busy_run = 0, busy_last = 0, busy_pulses = 0;
    always @(posedge clk) begin
        if (busy) busy_run <= busy_run + 1;
        else if (busy_run != 0) begin
            busy_last   <= busy_run;
            busy_run    <= 0;
            busy_pulses <= busy_pulses + 1;
        end
    end

    // bus driver
    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b0; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b1; qw();
    endtask

    task automatic put_bit(input bit b);
        sda_m = b; qw();
        scl_m = 1'b1; qw(); qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic get_bit(output bit b);
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        b = sda_line; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        bit b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(input bit master_ack, output logic [7:0] v);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!master_ack);
    endtask

    task automatic write_hdr(input logic [15:0] a, input string tag);
        bit ak;
        bus_start();
        send_byte({DEV, 1'b0}, ak);
        check(ak, {tag, " R2 device write ack"}, ak, 1);
        send_byte(a[15:8], ak);
        check(ak, {tag, " R3 high address ack"}, ak, 1);
        send_byte(a[7:0], ak);
        check(ak, {tag, " R3 low address ack"}, ak, 1);
    endtask

    task automatic write_data(input logic [7:0] v, input bit exp_ack, input string tag);
        bit ak;
        send_byte(v, ak);
        check(ak == exp_ack, tag, ak, exp_ack);
    endtask

    task automatic read_run(input int n, input string tag);
        bit ak;
        logic [7:0] v;
        bus_start();
        send_byte({DEV, 1'b1}, ak);
        check(ak, {tag, " R2 device read ack"}, ak, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, v);
            got_byte = v;
            -> got_ev;
            @(negedge clk);
        end
        bus_stop();
        check(sda_drive_low == 1'b0, {tag, " R7 released after nack"}, sda_drive_low, 0);
    endtask

    task automatic set_ptr(input logic [15:0] a, input string tag);
        write_hdr(a, tag);
        bus_stop();
    endtask

    task automatic wait_write_done(input string tag);
        int p0;
        p0 = busy_pulses;
        qw(); qw();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        check(busy_pulses == p0 + 1, {tag, " R4 one write cycle"}, busy_pulses - p0, 1);
        check(busy_last == WRC, {tag, " R4 busy width"}, busy_last, WRC);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        bit ak;
        int p0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(sda_drive_low == 1'b0, "R1 drive after reset", sda_drive_low, 0);
        ser_en_n = 1'b0;
        qw();

        // R1 / R7: reset contents from pointer 0
        expect_byte(8'h00, "R1 reset byte 0");
        expect_byte(8'h00, "R1 reset byte 1");
        read_run(2, "R1");

        // R2: wrong device address, then silence until next start
        bus_start();
        send_byte({7'h51, 1'b0}, ak);
        check(!ak, "R2 mismatch no ack", ak, 0);
        send_byte(8'h00, ak);
        check(!ak, "R2 no ack after mismatch", ak, 0);
        bus_stop();

        // R3 / R4: write three bytes at 3
        write_hdr(16'h0003, "W3");
        write_data(8'hA1, 1'b1, "R3 data ack 0");
        write_data(8'hB2, 1'b1, "R3 data ack 1");
        write_data(8'hC3, 1'b1, "R3 data ack 2");
        bus_stop();
        wait_write_done("W3");

        // R6: address-only write sets pointer without a write cycle
        p0 = busy_pulses;
        set_ptr(16'h0003, "R6");
        repeat (WRC + 20) @(negedge clk);
        check(busy_pulses == p0, "R6 no write cycle", busy_pulses - p0, 0);
        expect_byte(8'hA1, "R7 seq read 3");
        expect_byte(8'hB2, "R7 seq read 4");
        expect_byte(8'hC3, "R7 seq read 5");
        expect_byte(8'h00, "R7 seq read 6");
        read_run(4, "R7");

        // R8 / R3 modulo address: 0x1209 maps to 9
        write_hdr(16'h1209, "W9");
        write_data(8'h55, 1'b1, "R3 data ack at 9");
        bus_stop();
        wait_write_done("W9");
        expect_byte(8'h00, "R8 pointer after write");
        read_run(1, "R8");
        set_ptr(16'h0009, "R3m");
        expect_byte(8'h55, "R3 modulo address");
        read_run(1, "R3m");

        // R3 / R7 wrap
        write_hdr(16'h000E, "WE");
        write_data(8'h11, 1'b1, "R3 wrap ack 0");
        write_data(8'h22, 1'b1, "R3 wrap ack 1");
        write_data(8'h33, 1'b1, "R3 wrap ack 2");
        bus_stop();
        wait_write_done("WE");
        set_ptr(16'h000E, "RE");
        expect_byte(8'h11, "R3 wrap byte 14");
        expect_byte(8'h22, "R3 wrap byte 15");
        expect_byte(8'h33, "R7 wrap read byte 0");
        read_run(3, "RE");

        // R9: repeated start discards buffered write
        p0 = busy_pulses;
        write_hdr(16'h0005, "W5");
        write_data(8'h77, 1'b1, "R9 data ack");
        set_ptr(16'h0005, "R9");
        repeat (WRC + 20) @(negedge clk);
        check(busy_pulses == p0, "R9 no write cycle", busy_pulses - p0, 0);
        expect_byte(8'hC3, "R9 old byte kept");
        read_run(1, "R9");

        // R10: buffer overflow
        write_hdr(16'h0008, "W8");
        write_data(8'h01, 1'b1, "R10 ack 0");
        write_data(8'h02, 1'b1, "R10 ack 1");
        write_data(8'h03, 1'b1, "R10 ack 2");
        write_data(8'h04, 1'b1, "R10 ack 3");
        write_data(8'h05, 1'b0, "R10 no ack past limit");
        bus_stop();
        wait_write_done("W8");
        set_ptr(16'h0008, "R10");
        expect_byte(8'h01, "R10 byte 8");
        expect_byte(8'h02, "R10 byte 9");
        expect_byte(8'h03, "R10 byte 10");
        expect_byte(8'h04, "R10 byte 11");
        expect_byte(8'h00, "R10 byte 12 untouched");
        read_run(5, "R10");

        // R5: traffic during the write cycle is ignored
        write_hdr(16'h0000, "W0");
        write_data(8'h99, 1'b1, "R5 data ack");
        bus_stop();
        check(busy == 1'b1, "R5 busy after stop", busy, 1);
        bus_start();
        send_byte({DEV, 1'b1}, ak);
        check(!ak, "R5 no ack while busy", ak, 0);
        check(busy == 1'b1, "R5 still busy", busy, 1);
        bus_stop();
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        set_ptr(16'h0000, "R5");
        expect_byte(8'h99, "R5 committed byte");
        read_run(1, "R5");

        // R11: interface disabled
        ser_en_n = 1'b1;
        qw();
        bus_start();
        send_byte({DEV, 1'b0}, ak);
        check(!ak, "R11 no ack when disabled", ak, 0);
        check(sda_drive_low == 1'b0, "R11 no drive when disabled", sda_drive_low, 0);
        bus_stop();
        ser_en_n = 1'b0;
        qw();

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule